// File: doc/BRIEF.md
# Programmable Sample-Rate Clock Divider

This block derives a bit clock from a reference by counting reference ticks. The reference is either the system clock itself or an external clock. The external clock is never used as a clock: it is brought into the system clock domain through a synchronizer, and each of its rising edges becomes a one-cycle tick. An eight-bit divide value sets the length of the output period. The output high phase and low phase follow a fixed rule that depends on whether the divide value is even or odd.

Besides the divided clock level, the block gives two one-cycle enables. One marks the first system cycle of each high phase and the other marks the first system cycle of each low phase. A serial shifter in the same clock domain uses these enables to launch and capture data without a second clock. A divide value written while the block is running takes effect only when the next output period begins, so the current period always has a consistent high and low width. The usual half-rate setting is system clock source with divide equal to 1.

Top module: `sample_rate_div`

## Requirements
- R1: While rstN is low, bitClk, riseEn and fallEn are 0. After reset the counter stands at the start of a period, so the first reference tick after release starts a high phase. With the system source, riseEn is therefore 1 in the first cycle after that tick's clock edge.
- R2: With useCpuSrc = 1, one output period (high run plus low run of bitClk, in system cycles) lasts divide + 1 cycles.
- R3: For an even divide value d (d > 0), bitClk stays high for d/2 + 1 reference ticks and low for d/2 reference ticks.
- R4: For an odd divide value d, bitClk stays high and low for (d + 1)/2 reference ticks each.
- R5: With divide = 0, the period is one reference tick. bitClk stays high, riseEn is 1 on every tick and fallEn is never 1.
- R6: riseEn is 1 for exactly one cycle, in the first cycle that bitClk is high. fallEn is 1 for exactly one cycle, in the first cycle that bitClk is low. The two enables are never 1 together.
- R7: With useCpuSrc = 0, every rising edge of extClkIn that is seen through a SYNC_STAGES-flop synchronizer makes one reference tick. Phase lengths then count in extClkIn periods: divide = 2 with extClkIn period of 6 system cycles gives a high run of 12 cycles and a low run of 6 cycles.
- R8: A change of divide during an output period does not change that period. The new value sets the widths from the next period onward.
- R9: With useCpuSrc = 1 and divide = 1, bitClk toggles on every system cycle, which is half the system clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic runs on it |
| rstN | input | 1 | Active-low synchronous reset |
| useCpuSrc | input | 1 | 1: the system clock is the reference; 0: extClkIn is the reference |
| extClkIn | input | 1 | External reference clock; asynchronous, sampled |
| divide | input | DIV_W (8) | Divide value; period = divide + 1 reference ticks |
| bitClk | output | 1 | Divided clock level |
| riseEn | output | 1 | One-cycle enable in the first high cycle of bitClk |
| fallEn | output | 1 | One-cycle enable in the first low cycle of bitClk |

## Verification
The hardest case to set up from the ports is a divide change that lands inside a running period. The stimulus waits for riseEn and writes the new value in that same cycle, while the counter is in the middle of the old high phase. It then measures the rest of that period against the old widths and the following period against the new widths. The external-source case is also indirect, because ticks come only through the synchronizer. A free-running extClkIn with a fixed period of six system cycles is driven, and the bench discards the first period after the switch so that the measured phases are whole multiples of the external period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef struct packed {
    logic tick;       // one reference tick this cycle
    logic beginHigh;  // this tick starts a high phase
    logic beginLow;   // this tick starts a low phase
  } divStrobes_t;

  // High-phase length in ticks for a divide value d: d/2+1 when d is even, (d+1)/2 when d is odd.
  function automatic logic [8:0] highTicks(input logic [7:0] d);
    logic [8:0] ext;
    ext = {1'b0, d};
    if (d[0]) highTicks = (ext + 9'd1) >> 1;
    else      highTicks = (ext >> 1) + 9'd1;
  endfunction

endpackage

// File: rtl/clkdiv_src_sync.sv
module clkdiv_src_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic useCpuSrc,
  input  logic extClkIn,
  output logic tick
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain;
  logic extEdge;

  generate
    for (genvar s = 0; s < CHAIN_W; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= extClkIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign extEdge = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  assign tick    = useCpuSrc | extEdge;

  // External ticks come from edges and so are never in consecutive cycles.
  assert_ext_tick_spaced_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!useCpuSrc && tick) |=> (useCpuSrc || !tick));

endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [DIV_W-1:0] divide,
  output divStrobes_t      strobes
);
  logic [DIV_W-1:0] pos;
  logic [DIV_W-1:0] activeDiv;
  logic [DIV_W-1:0] curDiv;
  logic [DIV_W:0]   hiNow;
  logic             atStart;
  logic             atWrap;

  assign atStart = (pos == '0);
  assign curDiv  = atStart ? divide : activeDiv;
  assign hiNow   = highTicks(curDiv);
  assign atWrap  = (pos == curDiv);

  always_comb begin
    strobes.tick      = tick;
    strobes.beginHigh = tick && atStart;
    strobes.beginLow  = tick && ({1'b0, pos} == hiNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos       <= '0;
      activeDiv <= '0;
    end else if (tick) begin
      if (atStart) activeDiv <= divide;
      pos <= atWrap ? '0 : pos + 1'b1;
    end
  end

  // Inside a period the position never passes the latched divide value.
  assert_pos_in_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pos != '0) |-> (pos <= activeDiv));

  // Away from a period start the latched divide value is held.
  assert_div_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pos != '0) |=> $stable(activeDiv));

endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  divStrobes_t strobes,
  output logic        bitClk,
  output logic        riseEn,
  output logic        fallEn
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitClk <= 1'b0;
      riseEn <= 1'b0;
      fallEn <= 1'b0;
    end else begin
      riseEn <= strobes.beginHigh;
      fallEn <= strobes.beginLow;
      if (strobes.beginHigh)     bitClk <= 1'b1;
      else if (strobes.beginLow) bitClk <= 1'b0;
    end
  end

  assert_edges_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(riseEn && fallEn));

  assert_rise_in_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    riseEn |-> bitClk);

  assert_fall_in_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    fallEn |-> !bitClk);

endmodule

// File: rtl/sample_rate_div.sv
module sample_rate_div
  import clkdiv_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             useCpuSrc,
  input  logic             extClkIn,
  input  logic [DIV_W-1:0] divide,
  output logic             bitClk,
  output logic             riseEn,
  output logic             fallEn
);
  logic        tick;
  divStrobes_t strobes;
  logic        resetSeen;

  clkdiv_src_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .useCpuSrc(useCpuSrc), .extClkIn(extClkIn), .tick(tick)
  );

  clkdiv_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .divide(divide), .strobes(strobes)
  );

  clkdiv_datapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .bitClk(bitClk), .riseEn(riseEn), .fallEn(fallEn)
  );

  always_ff @(posedge clk) begin
    if (!rstN) resetSeen <= 1'b1;
  end

  assert_reset_low_R1: assert property (@(posedge clk)
    (resetSeen && !$past(rstN)) |-> (!bitClk && !riseEn && !fallEn));

  assert_rise_flagged_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitClk) |-> riseEn);

  assert_fall_flagged_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bitClk) |-> fallEn);

endmodule

// File: tb/sample_rate_div_test.sv
module sample_rate_div_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic useCpuSrc = 1'b1;
  logic extClkIn = 1'b0;
  logic [7:0] divide = 8'd4;
  logic bitClk, riseEn, fallEn;
  logic extRun = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_rate_div uut (
    .clk(clk), .rstN(rstN), .useCpuSrc(useCpuSrc), .extClkIn(extClkIn),
    .divide(divide), .bitClk(bitClk), .riseEn(riseEn), .fallEn(fallEn)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitRise();
    int n = 0;
    @(negedge clk);
    while (!riseEn && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Called at a negedge where riseEn is 1; returns at the next such negedge.
  task automatic countFrom(input string req, output int hi, output int lo);
    int n = 0;
    hi = 0;
    lo = 0;
    while (bitClk && n < 2000) begin
      if (hi > 0 && riseEn) check(req, "riseEn repeated in high phase", 1, 0);
      hi++;
      n++;
      @(negedge clk);
    end
    check("R6", "fallEn in first low cycle", fallEn, 1);
    while (!bitClk && n < 2000) begin
      if (lo > 0 && fallEn) check("R6", "fallEn repeated in low phase", 1, 0);
      lo++;
      n++;
      @(negedge clk);
    end
    check("R6", "riseEn in first high cycle", riseEn, 1);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1", "bitClk in reset", bitClk, 0);
    check("R1", "riseEn in reset", riseEn, 0);
    check("R1", "fallEn in reset", fallEn, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "riseEn after first tick", riseEn, 1);
    check("R1", "bitClk after first tick", bitClk, 1);
  endtask

  task automatic testDivide(input string req, input int d);
    int hi, lo, expHi;
    divide = 8'(d);
    waitRise();
    countFrom(req, hi, lo);
    expHi = (d % 2 == 0) ? d/2 + 1 : (d + 1)/2;
    check(req, $sformatf("high run d=%0d", d), hi, expHi);
    check(req, $sformatf("low run d=%0d", d), lo, d + 1 - expHi);
    check("R2", $sformatf("period d=%0d", d), hi + lo, d + 1);
  endtask

  task automatic testMidChange();
    int hi, lo;
    divide = 8'd4;
    waitRise();
    countFrom("R8", hi, lo);
    divide = 8'd7;            // written during the first high cycle
    countFrom("R8", hi, lo);
    check("R8", "current period high keeps old value", hi, 3);
    check("R8", "current period low keeps old value", lo, 2);
    countFrom("R8", hi, lo);
    check("R8", "next period high uses new value", hi, 4);
    check("R8", "next period low uses new value", lo, 4);
  endtask

  task automatic testZero();
    int badRise = 0, badFall = 0, badLvl = 0;
    divide = 8'd0;
    waitRise();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!riseEn) badRise++;
      if (fallEn) badFall++;
      if (!bitClk) badLvl++;
      @(negedge clk);
    end
    check("R5", "cycles without riseEn", badRise, 0);
    check("R5", "cycles with fallEn", badFall, 0);
    check("R5", "cycles with bitClk low", badLvl, 0);
  endtask

  task automatic testHalfRate();
    int bad = 0;
    logic prev;
    divide = 8'd1;
    waitRise();
    repeat (2) @(negedge clk);
    prev = bitClk;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (bitClk == prev) bad++;
      prev = bitClk;
    end
    check("R9", "cycles without toggle at divide 1", bad, 0);
  endtask

  task automatic testExternal();
    int hi, lo;
    extRun = 1'b1;
    useCpuSrc = 1'b0;
    divide = 8'd2;
    waitRise();
    countFrom("R7", hi, lo);
    countFrom("R7", hi, lo);
    check("R7", "high run with external source", hi, 12);
    check("R7", "low run with external source", lo, 6);
    useCpuSrc = 1'b1;
    extRun = 1'b0;
  endtask

  initial begin : extDriver
    forever begin
      @(negedge clk);
      if (extRun) begin
        repeat (2) @(negedge clk);
        extClkIn = ~extClkIn;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    testReset();
    testDivide("R3", 4);
    testDivide("R3", 6);
    testDivide("R3", 254);
    testDivide("R4", 1);
    testDivide("R4", 3);
    testDivide("R4", 255);
    testMidChange();
    testZero();
    testHalfRate();
    testExternal();
    testDivide("R3", 2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule